// File: doc/BRIEF.md
# PHY Control-Port Handshake Sequencer

This block is a hardware master for the internal 16-bit register space of a serial link PHY. The PHY exposes that space through a control port made of a 16-bit input data bus, four request strobes (capture address, capture data, write, read), a single acknowledge line and a 16-bit output data bus. Each strobe is driven through a complete four-phase exchange: raise the strobe, see acknowledge rise, drop the strobe, see acknowledge fall. Every acknowledge wait has a bounded number of probes, and when the probes run out the operation ends with a timeout.

A user-side port takes one command at a time. It can select a register address, write a value to the selected register, read the selected register, or run a PHY reset. The reset writes the reset bit into the PHY clock/reset register and then polls the lane status register until the receive PLL reports lock. The reset waits until the PHY PLL clock enable has been steady for a settling interval. All delays are counted in clock cycles, derived from a clock-frequency parameter in MHz.

State machine states: IDLE (waiting for a command), SETTLE (waiting for the PLL enable to settle), ADDR (capture-address exchange), DATA (capture-data exchange), WRITE (write exchange), FIRE (one-cycle write strobe without acknowledge), READ (read exchange), GAP (delay between lock polls) and DONE (completion cycle). Transitions: IDLE→ADDR/DATA/READ/SETTLE on a command; SETTLE→ADDR once settled; ADDR→DONE (select), ADDR→DATA (reset, first pass), ADDR→READ (reset, polling); DATA→FIRE when value bit 0 is set, otherwise DATA→WRITE; WRITE→DONE; FIRE→GAP (reset) or FIRE→DONE; READ→DONE (plain read, lock seen, or tries used up) or READ→GAP (no lock yet); GAP→ADDR; any exchange timeout →DONE; DONE→IDLE.

Top module: `phy_cr_seq`

## Requirements
- R1: At most one strobe is high at any time, every strobe is driven as a four-phase exchange (raise, acknowledge high, drop, acknowledge low), and the input data bus does not change while a strobe stays high.
- R2: Command code 0 (select) places cmd_data on the PHY input bus and runs one exchange on the capture-address strobe, so the PHY latches that address.
- R3: Command code 1 (write) with cmd_data bit 0 clear places cmd_data on the PHY input bus, runs an exchange on capture-data and then an exchange on the write strobe, and ends without error.
- R4: A write whose value has bit 0 set raises the write strobe for exactly one cycle after the capture-data exchange and completes without waiting for acknowledge.
- R5: Command code 2 (read) runs an exchange on the read strobe, captures the PHY output bus while acknowledge is high and presents it on rd_data when done pulses.
- R6: Each acknowledge wait probes acknowledge at most ACK_CHECKS times, the probes POLL_US microseconds apart; when all fail in either the rising or falling phase the operation ends with err_timeout and all strobes low.
- R7: Command code 3 (PHY reset) starts no PHY access until pll_clk_en has been high for SETTLE_US microseconds without interruption.
- R8: The reset selects register 0x7F3F and writes 0x0001 to it (reset bit 0), which takes the no-acknowledge write path of R4.
- R9: After that write the reset repeats, up to PLL_TRIES times: wait POLL_US microseconds, select register 0x2003, read it; it ends without error on the first read with bit 1 (receive PLL locked) set.
- R10: When PLL_TRIES reads of register 0x2003 all show bit 1 clear, the reset ends with err_timeout.
- R11: busy is high from the cycle after a command is accepted until the cycle after done; a command presented while busy is high is ignored.
- R12: done is a single-cycle pulse at the end of every operation, err_timeout is high only together with done, and while idle (also after synchronous reset) all strobes are low and the PHY input bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pll_clk_en | input | 1 | PHY PLL clock enable, watched before a reset command |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 select, 1 write, 2 read, 3 PHY reset |
| cmd_data | input | 16 | Address for select, value for write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Operation ended by an acknowledge or lock timeout |
| rd_data | output | 16 | Last value captured from the PHY |
| cr_data_in | output | 16 | Address/data bus to the PHY |
| cr_cap_addr | output | 1 | Capture-address strobe |
| cr_cap_data | output | 1 | Capture-data strobe |
| cr_write | output | 1 | Write strobe |
| cr_read | output | 1 | Read strobe |
| cr_ack | input | 1 | Acknowledge from the PHY |
| cr_data_out | input | 16 | Read data from the PHY |

## Verification
The hardest situations to reach are the ones where the PHY misbehaves: an acknowledge that never rises, one that never falls, a muted acknowledge on a reset-bit write, and a PLL that locks late or never. The bench PHY model has switches that hold acknowledge low or high, an adjustable acknowledge latency, and a count of status reads that return "unlocked" before lock appears, so poll success on a chosen try and full poll exhaustion are both driven directly. The settling wait is reached by dropping the PLL enable before issuing a reset and raising it after a hold-off.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    typedef enum logic [1:0] {
        OP_SEL = 2'd0,
        OP_WR  = 2'd1,
        OP_RD  = 2'd2,
        OP_RST = 2'd3
    } cr_op_e;

    typedef enum logic [3:0] {
        M_IDLE,
        M_SETTLE,
        M_ADDR,
        M_DATA,
        M_WRITE,
        M_FIRE,
        M_READ,
        M_GAP,
        M_DONE
    } main_st_e;

    typedef enum logic [1:0] {
        H_IDLE,
        H_RISE,
        H_FALL
    } hs_st_e;

    localparam int STB_W    = 4;
    localparam int STB_ADDR = 0;
    localparam int STB_DATA = 1;
    localparam int STB_WR   = 2;
    localparam int STB_RD   = 3;

    localparam logic [15:0] PHY_RST_REG  = 16'h7F3F;
    localparam logic [15:0] PHY_LANE_REG = 16'h2003;
    localparam logic [15:0] PHY_RST_VAL  = 16'h0001;
    localparam int          RST_BIT      = 0;
    localparam int          LOCK_BIT     = 1;

endpackage

// File: rtl/phy_cr_handshake.sv
module phy_cr_handshake
    import phy_cr_pkg::*;
#(
    parameter int DW         = 16,
    parameter int POLL_CYC   = 10000,
    parameter int ACK_CHECKS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [STB_W-1:0] sel,
    input  logic             ack,
    input  logic [DW-1:0]    dout,
    output logic [STB_W-1:0] stb,
    output logic [DW-1:0]    cap,
    output logic             fin,
    output logic             tmo
);
    localparam int TW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int CW = (ACK_CHECKS > 1) ? $clog2(ACK_CHECKS) : 1;
    localparam logic [TW-1:0] TMR_RELOAD = TW'(POLL_CYC - 1);
    localparam logic [CW-1:0] LAST_CHK   = CW'(ACK_CHECKS - 1);

    hs_st_e        st, nxt;
    logic [TW-1:0] tmr;
    logic [CW-1:0] chk;
    logic          probe, hit, give_up;

    // a probe happens when the spacing timer has run out
    always_comb begin
        probe   = (tmr == '0);
        hit     = probe && ((st == H_RISE) ? ack : !ack);
        give_up = probe && !hit && (chk == LAST_CHK);
    end

    always_comb begin
        nxt = st;
        unique case (st)
            H_IDLE:  if (start) nxt = H_RISE;
            H_RISE: begin
                if (hit)          nxt = H_FALL;
                else if (give_up) nxt = H_IDLE;
            end
            H_FALL:  if (hit || give_up) nxt = H_IDLE;
            default: nxt = H_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= H_IDLE;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb <= '0;
            tmr <= '0;
            chk <= '0;
            cap <= '0;
            fin <= 1'b0;
            tmo <= 1'b0;
        end else begin
            fin <= 1'b0;
            tmo <= 1'b0;
            unique case (st)
                H_IDLE: begin
                    if (start) begin
                        stb <= sel;
                        tmr <= '0;
                        chk <= '0;
                    end
                end
                H_RISE, H_FALL: begin
                    if (!probe) begin
                        tmr <= tmr - TW'(1);
                    end else if (hit) begin
                        chk <= '0;
                        if (st == H_RISE) begin
                            cap <= dout;
                            stb <= '0;
                        end else begin
                            fin <= 1'b1;
                        end
                    end else if (give_up) begin
                        stb <= '0;
                        tmo <= 1'b1;
                    end else begin
                        chk <= chk + CW'(1);
                        tmr <= TMR_RELOAD;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/phy_cr_timer.sv
module phy_cr_timer #(
    parameter int CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            expired <= (cnt == CW'(1)) && !load;
            if (load)             cnt <= CW'(CYC);
            else if (cnt != '0)   cnt <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/phy_cr_settle.sv
module phy_cr_settle #(
    parameter int CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic ready
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // counts consecutive cycles of en, saturating at CYC
    always_ff @(posedge clk) begin
        if (rst || !en)            cnt <= '0;
        else if (cnt != CW'(CYC))  cnt <= cnt + CW'(1);
    end

    assign ready = (cnt == CW'(CYC));

endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int DW         = 16,
    parameter int CLK_MHZ    = 100,
    parameter int POLL_US    = 100,
    parameter int SETTLE_US  = 100,
    parameter int ACK_CHECKS = 10,
    parameter int PLL_TRIES  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pll_clk_en,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          busy,
    output logic          done,
    output logic          err_timeout,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] cr_data_in,
    output logic          cr_cap_addr,
    output logic          cr_cap_data,
    output logic          cr_write,
    output logic          cr_read,
    input  logic          cr_ack,
    input  logic [DW-1:0] cr_data_out
);
    localparam int POLL_CYC   = CLK_MHZ * POLL_US;
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int TRY_W      = $clog2(PLL_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(PLL_TRIES - 1);

    main_st_e         st, nxt;
    cr_op_e           op;
    logic             polling;
    logic [TRY_W-1:0] tries;
    logic [DW-1:0]    din, rdq;
    logic             done_q, err_q, hs_start, gap_start, fire_q;
    logic             nxt_err;

    logic [STB_W-1:0] hs_sel, hs_stb;
    logic [DW-1:0]    hs_cap;
    logic             hs_fin, hs_tmo, gap_exp, settle_ok, lock_seen;

    phy_cr_handshake #(
        .DW        (DW),
        .POLL_CYC  (POLL_CYC),
        .ACK_CHECKS(ACK_CHECKS)
    ) u_hs (
        .clk  (clk),
        .rst  (rst),
        .start(hs_start),
        .sel  (hs_sel),
        .ack  (cr_ack),
        .dout (cr_data_out),
        .stb  (hs_stb),
        .cap  (hs_cap),
        .fin  (hs_fin),
        .tmo  (hs_tmo)
    );

    phy_cr_timer #(.CYC(POLL_CYC)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load   (gap_start),
        .expired(gap_exp)
    );

    phy_cr_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .en   (pll_clk_en),
        .ready(settle_ok)
    );

    assign lock_seen = hs_cap[LOCK_BIT];

    // strobe selection follows the exchange state
    always_comb begin
        hs_sel           = '0;
        hs_sel[STB_ADDR] = (st == M_ADDR);
        hs_sel[STB_DATA] = (st == M_DATA);
        hs_sel[STB_WR]   = (st == M_WRITE);
        hs_sel[STB_RD]   = (st == M_READ);
    end

    always_comb begin
        nxt     = st;
        nxt_err = 1'b0;
        unique case (st)
            M_IDLE: begin
                if (cmd_valid) begin
                    unique case (cr_op_e'(cmd_op))
                        OP_SEL:  nxt = M_ADDR;
                        OP_WR:   nxt = M_DATA;
                        OP_RD:   nxt = M_READ;
                        OP_RST:  nxt = M_SETTLE;
                        default: nxt = M_IDLE;
                    endcase
                end
            end
            M_SETTLE: if (settle_ok) nxt = M_ADDR;
            M_ADDR: begin
                if (hs_tmo) begin
                    nxt     = M_DONE;
                    nxt_err = 1'b1;
                end else if (hs_fin) begin
                    if (op != OP_RST) nxt = M_DONE;
                    else if (polling) nxt = M_READ;
                    else              nxt = M_DATA;
                end
            end
            M_DATA: begin
                if (hs_tmo) begin
                    nxt     = M_DONE;
                    nxt_err = 1'b1;
                end else if (hs_fin) begin
                    nxt = din[RST_BIT] ? M_FIRE : M_WRITE;
                end
            end
            M_WRITE: begin
                if (hs_tmo) begin
                    nxt     = M_DONE;
                    nxt_err = 1'b1;
                end else if (hs_fin) begin
                    nxt = M_DONE;
                end
            end
            M_FIRE: nxt = (op == OP_RST) ? M_GAP : M_DONE;
            M_READ: begin
                if (hs_tmo) begin
                    nxt     = M_DONE;
                    nxt_err = 1'b1;
                end else if (hs_fin) begin
                    if (op != OP_RST || lock_seen) begin
                        nxt = M_DONE;
                    end else if (tries == LAST_TRY) begin
                        nxt     = M_DONE;
                        nxt_err = 1'b1;
                    end else begin
                        nxt = M_GAP;
                    end
                end
            end
            M_GAP:   if (gap_exp) nxt = M_ADDR;
            M_DONE:  nxt = M_IDLE;
            default: nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= M_IDLE;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op        <= OP_SEL;
            polling   <= 1'b0;
            tries     <= '0;
            din       <= '0;
            rdq       <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            hs_start  <= 1'b0;
            gap_start <= 1'b0;
            fire_q    <= 1'b0;
        end else begin
            hs_start  <= (nxt != st) && (nxt inside {M_ADDR, M_DATA, M_WRITE, M_READ});
            gap_start <= (nxt == M_GAP) && (st != M_GAP);
            fire_q    <= (nxt == M_FIRE);
            done_q    <= (nxt == M_DONE);
            err_q     <= nxt_err;

            if (st == M_IDLE && cmd_valid) begin
                op  <= cr_op_e'(cmd_op);
                din <= (cmd_op == OP_SEL || cmd_op == OP_WR) ? cmd_data : '0;
            end
            if (st == M_SETTLE && settle_ok)
                din <= DW'(PHY_RST_REG);
            if (st == M_ADDR && hs_fin && op == OP_RST && !polling)
                din <= DW'(PHY_RST_VAL);
            if (st == M_GAP && gap_exp) begin
                din     <= DW'(PHY_LANE_REG);
                polling <= 1'b1;
            end
            if (st == M_READ && hs_fin) begin
                rdq <= hs_cap;
                if (op == OP_RST && !lock_seen) tries <= tries + TRY_W'(1);
            end
            if (nxt == M_DONE) begin
                din     <= '0;
                polling <= 1'b0;
                tries   <= '0;
            end
        end
    end

    assign busy        = (st != M_IDLE);
    assign done        = done_q;
    assign err_timeout = err_q;
    assign rd_data     = rdq;
    assign cr_data_in  = din;
    assign cr_cap_addr = hs_stb[STB_ADDR];
    assign cr_cap_data = hs_stb[STB_DATA];
    assign cr_write    = hs_stb[STB_WR] | fire_q;
    assign cr_read     = hs_stb[STB_RD];

endmodule

// File: rtl/phy_cr_seq_chk.sv
module phy_cr_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          err_timeout,
    input logic          cr_cap_addr,
    input logic          cr_cap_data,
    input logic          cr_write,
    input logic          cr_read,
    input logic [DW-1:0] cr_data_in
);
    logic [3:0] stbs;
    assign stbs = {cr_read, cr_write, cr_cap_data, cr_cap_addr};

    // R1: never two strobes at once
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stbs));

    // R1: data bus held while a strobe stays up
    a_r1_data_held: assert property (@(posedge clk) disable iff (rst)
        (|stbs) |=> (!(|stbs) || $stable(cr_data_in)));

    // R4: a reset-bit write strobe lasts one cycle
    a_r4_fire_once: assert property (@(posedge clk) disable iff (rst)
        (cr_write && cr_data_in[0]) |=> !cr_write);

    // R6: an aborted operation leaves every strobe low
    a_r6_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> (stbs == 4'b0000));

    // R12: done is a single pulse, inside the busy window
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_done_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R12: error only reported with done
    a_r12_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> done);

    // R12: quiet control port while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (stbs == 4'b0000 && cr_data_in == '0));

endmodule

bind phy_cr_seq phy_cr_seq_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .err_timeout(err_timeout),
    .cr_cap_addr(cr_cap_addr),
    .cr_cap_data(cr_cap_data),
    .cr_write   (cr_write),
    .cr_read    (cr_read),
    .cr_data_in (cr_data_in)
);

// File: tb/tb_phy_cr_seq.sv
`timescale 1ns/1ps
module tb_phy_cr_seq;
    localparam int POLL    = 6;
    localparam int SETTLE  = 30;
    localparam int CHECKS  = 10;
    localparam int TRIES   = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        pll_en;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_data;
    logic        busy, done, err_to;
    logic [15:0] rd_data, cr_din;
    logic        ca, cd, wr, rd;
    logic        m_ack;
    logic [15:0] m_dout;

    always #5 clk = ~clk;

    phy_cr_seq #(
        .DW(16), .CLK_MHZ(1), .POLL_US(POLL), .SETTLE_US(SETTLE),
        .ACK_CHECKS(CHECKS), .PLL_TRIES(TRIES)
    ) dut (
        .clk(clk), .rst(rst), .pll_clk_en(pll_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .busy(busy), .done(done), .err_timeout(err_to), .rd_data(rd_data),
        .cr_data_in(cr_din), .cr_cap_addr(ca), .cr_cap_data(cd),
        .cr_write(wr), .cr_read(rd), .cr_ack(m_ack), .cr_data_out(m_dout)
    );

    // ---------------- PHY model ----------------
    int          lat = 1;
    bit          stuck_lo = 1'b0;
    bit          stuck_hi = 1'b0;
    int          lock_after = 0;
    logic [15:0] m_mem [16];
    logic [15:0] m_addr, m_dat;
    logic        p_ca, p_cd, p_wr, p_rd, lock;
    int          left, acnt;
    int          n_caddr, n_wr, n_stat, n_rst;
    logic        req;

    assign req    = ca | cd | rd | (wr & !m_dat[0]);
    assign m_dout = (m_addr == 16'h2003) ? {14'b0, lock, 1'b0} : m_mem[m_addr[3:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) m_mem[i] <= 16'h0;
            m_addr <= 16'h0; m_dat <= 16'h0;
            p_ca <= 0; p_cd <= 0; p_wr <= 0; p_rd <= 0;
            lock <= 1'b1; left <= 0; acnt <= 0; m_ack <= 1'b0;
            n_caddr <= 0; n_wr <= 0; n_stat <= 0; n_rst <= 0;
        end else begin
            p_ca <= ca; p_cd <= cd; p_wr <= wr; p_rd <= rd;
            if (ca && !p_ca) begin m_addr <= cr_din; n_caddr <= n_caddr + 1; end
            if (cd && !p_cd) m_dat <= cr_din;
            if (wr && !p_wr) begin
                n_wr <= n_wr + 1;
                if (m_addr == 16'h7F3F && m_dat[0]) begin
                    n_rst <= n_rst + 1; lock <= 1'b0; left <= lock_after;
                end else begin
                    m_mem[m_addr[3:0]] <= m_dat;
                end
            end
            if (rd && !p_rd && m_addr == 16'h2003) begin
                n_stat <= n_stat + 1;
                if (left == 0) lock <= 1'b1;
                else           left <= left - 1;
            end
            if (stuck_lo)      begin m_ack <= 1'b0; acnt <= 0; end
            else if (stuck_hi) begin m_ack <= 1'b1; acnt <= 0; end
            else if (req != m_ack) begin
                if (acnt + 1 >= lat) begin m_ack <= req; acnt <= 0; end
                else acnt <= acnt + 1;
            end else acnt <= 0;
        end
    end

    // ---------------- checking ----------------
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] exp_mem [16];

    task automatic check(input bit ok, input string req_s, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req_s, what, act, act, expv, expv);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = 16'h0;
    endtask

    task automatic wait_done(output int cyc, output logic e);
        cyc = 0;
        while (done !== 1'b1 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        e = err_to;
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R12", "done one cycle then idle",
              {busy, done}, 0);
    endtask

    task automatic run(input logic [1:0] op, input logic [15:0] d,
                       output int cyc, output logic e);
        issue(op, d);
        wait_done(cyc, e);
    endtask

    function automatic logic [15:0] pick_addr(input logic [31:0] r);
        return {4'h1, r[11:0]};
    endfunction

    initial begin
        int   cyc;
        logic e;
        int   base;
        rst = 1'b1; pll_en = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = 16'h0;
        for (int i = 0; i < 16; i++) exp_mem[i] = 16'h0;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check(busy == 0 && done == 0 && err_to == 0, "R12", "status after reset",
              {busy, done, err_to}, 0);
        check({ca, cd, wr, rd} == 4'b0 && cr_din == 16'h0, "R12", "port quiet after reset",
              {ca, cd, wr, rd}, 0);
        repeat (SETTLE + 5) @(negedge clk);

        // R2 / R3 / R5 directed
        base = n_caddr;
        run(2'd0, 16'h1005, cyc, e);
        check(e == 0 && m_addr == 16'h1005 && n_caddr == base + 1, "R2",
              "select latched address", m_addr, 16'h1005);
        base = n_wr;
        run(2'd1, 16'hA5A4, cyc, e);
        exp_mem[5] = 16'hA5A4;
        check(e == 0 && n_wr == base + 1, "R3", "write completed once", n_wr - base, 1);
        run(2'd2, 16'h0, cyc, e);
        check(e == 0 && rd_data == 16'hA5A4, "R5", "read back", rd_data, 16'hA5A4);

        // R4: reset-bit write with a muted acknowledge
        run(2'd0, 16'h1006, cyc, e);
        run(2'd1, 16'h0F01, cyc, e);
        exp_mem[6] = 16'h0F01;
        check(e == 0, "R4", "no-ack write ends without error", e, 0);
        check(cyc <= 3 * POLL + 8, "R4", "no-ack write is short", cyc, 3 * POLL + 8);
        run(2'd2, 16'h0, cyc, e);
        check(rd_data == 16'h0F01, "R4", "no-ack write stored", rd_data, 16'h0F01);

        // R11: command while busy is ignored
        lat = 4;
        run(2'd0, 16'h1005, cyc, e);
        base = n_wr;
        issue(2'd2, 16'h0);
        issue(2'd1, 16'hFFFF);
        wait_done(cyc, e);
        check(n_wr == base && rd_data == 16'hA5A4, "R11", "busy command dropped",
              n_wr - base, 0);
        lat = 1;

        // random traffic (R2, R3, R5)
        for (int it = 0; it < 24; it++) begin
            logic [15:0] a, v;
            a   = pick_addr($urandom);
            v   = $urandom;
            lat = $urandom_range(1, 4);
            run(2'd0, a, cyc, e);
            if ($urandom_range(0, 2) != 0) begin
                run(2'd1, v, cyc, e);
                exp_mem[a[3:0]] = v;
                check(e == 0, "R3", "random write status", e, 0);
            end else begin
                run(2'd2, 16'h0, cyc, e);
                check(e == 0 && rd_data == exp_mem[a[3:0]], "R5", "random read",
                      rd_data, exp_mem[a[3:0]]);
            end
        end
        lat = 1;

        // R6: acknowledge never rises
        stuck_lo = 1'b1;
        run(2'd0, 16'h1001, cyc, e);
        check(e == 1, "R6", "rise timeout flagged", e, 1);
        check(cyc >= (CHECKS - 1) * POLL && cyc <= (CHECKS - 1) * POLL + 10, "R6",
              "rise timeout length", cyc, (CHECKS - 1) * POLL);
        check({ca, cd, wr, rd} == 4'b0, "R6", "strobes low after abort", {ca, cd, wr, rd}, 0);
        stuck_lo = 1'b0;
        repeat (10) @(negedge clk);

        // R6: acknowledge never falls
        stuck_hi = 1'b1;
        run(2'd2, 16'h0, cyc, e);
        check(e == 1, "R6", "fall timeout flagged", e, 1);
        stuck_hi = 1'b0;
        repeat (10) @(negedge clk);

        // R8 / R9: reset with late lock
        lock_after = 3;
        base = n_stat;
        begin
            int r0;
            r0 = n_rst;
            run(2'd3, 16'h0, cyc, e);
            check(n_rst == r0 + 1, "R8", "reset bit written to 0x7F3F", n_rst - r0, 1);
        end
        check(e == 0 && rd_data[1] == 1'b1, "R9", "lock found", {e, rd_data[1]}, 1);
        check(n_stat == base + 4, "R9", "status reads until lock", n_stat - base, 4);
        check(cyc >= 4 * POLL, "R9", "poll spacing", cyc, 4 * POLL);

        // R10: lock never comes
        lock_after = 50;
        base = n_stat;
        run(2'd3, 16'h0, cyc, e);
        check(e == 1, "R10", "poll exhaustion flagged", e, 1);
        check(n_stat == base + TRIES, "R10", "status read count", n_stat - base, TRIES);

        // R7: settling wait on the PLL enable
        lock_after = 0;
        pll_en = 1'b0;
        @(negedge clk);
        base = n_caddr;
        issue(2'd3, 16'h0);
        repeat (40) @(negedge clk);
        check(n_caddr == base && busy == 1'b1, "R7", "no access before enable",
              n_caddr - base, 0);
        pll_en = 1'b1;
        begin
            int k;
            k = 0;
            while (n_caddr == base && k < 1000) begin
                @(negedge clk);
                k++;
            end
            check(k >= SETTLE && k <= SETTLE + 10, "R7", "settle interval", k, SETTLE);
        end
        wait_done(cyc, e);
        check(e == 0, "R7", "reset after settle succeeds", e, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule